// File: doc/BRIEF.md
# Serial Video Link Transmitter Encoder

This block turns a stream of parallel video words into one serial bit per fast clock. The fast clock runs at ten times the word rate and comes from outside the block. Each word is 10 bits wide. When the narrow mode pin is high, only the upper eight lines of the word bus carry data, and the block first widens the byte to 10 bits. A flag from the source marks bytes that belong to a timing reference sequence, and those bytes are widened differently from ordinary samples.

Each widened word goes into a shift register and leaves least significant bit first. The bits then pass through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1. After that, a transition coder changes the line level for every scrambled one. A receiver can recover the data from level changes alone, so it works even if the line polarity is swapped. The source raises the word strobe once to set the word phase. From then on, an internal modulo-ten counter takes a new word every tenth fast-clock cycle.

Top module: `serial_video_encoder`

## Requirements
- R1: After synchronous reset, `serial_out` is 0. It stays 0 until the first `word_stb` pulse is sampled.
- R2: The clock edge that samples the first `word_stb` loads a word. After that, a word is loaded every 10 clock edges, with no gap, and `word_stb` matters only on those load edges.
- R3: A loaded word is sent least significant bit first. Bit k of a word loaded at edge E is fed to the scrambler at edge E+1+k.
- R4: With `mode_8bit` = 0, the full `word_in` value is sent unchanged, whatever the value of `trs_flag`.
- R5: With `mode_8bit` = 1, `trs_flag` = 1 and `word_in[9:2]` = 0xFF, the word sent is 0x3FF.
- R6: With `mode_8bit` = 1, `trs_flag` = 1 and `word_in[9:2]` = 0x00, the word sent is 0x000.
- R7: With `mode_8bit` = 1 in all other cases, the word sent is `{word_in[9:2], 2'b00}`. Here `word_in[1:0]` is ignored. This covers 0xFF when `trs_flag` = 0, and any other byte when `trs_flag` = 1.
- R8: The scrambled bit is s(n) = b(n) XOR s(n-4) XOR s(n-9). Its history starts at zero at reset and is never cleared between words.
- R9: `serial_out` toggles at an edge exactly when the scrambled bit taken at that edge is 1. A receiver therefore gets s(n) back from the XOR of two successive output levels, whatever the line polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, ten times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| mode_8bit | input | 1 | 1: byte on `word_in[9:2]` is widened; 0: 10-bit word |
| word_stb | input | 1 | Word phase strobe; the first pulse starts framing |
| trs_flag | input | 1 | Marks the current word as part of a timing reference sequence |
| word_in | input | 10 | Parallel video word |
| serial_out | output | 1 | Scrambled, transition-coded serial line |

## Verification
The checker assumes the source never raises `word_stb` after framing has started except on a load edge. It also assumes `mode_8bit`, `trs_flag` and `word_in` are valid on those edges. The word-period assertion depends on both assumptions. The bench meets them in two ways: it drives every word from one task that raises the strobe exactly on the load edge, and it keeps the stream gap-free once the first word has gone in. The reset hold lasts several clock edges, so that the toggle check compares two defined output levels.

// File: rtl/svenc_pkg.sv
package svenc_pkg;

    localparam int WORD_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int SCR_LEN = 9;
    localparam int SCR_TAP = 4;

    typedef enum logic {
        SER_WAIT = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_e;

    typedef struct packed {
        logic              narrow;
        logic              trs;
        logic [WORD_W-1:0] data;
    } vid_word_t;

    function automatic logic [SCR_LEN-1:0] tap_mask(input int len, input int tap);
        logic [SCR_LEN-1:0] m;
        m = '0;
        m[len-1] = 1'b1;
        m[tap-1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/svenc_widener.sv
module svenc_widener #(
    parameter int WORD_W = svenc_pkg::WORD_W,
    parameter int BYTE_W = svenc_pkg::BYTE_W
) (
    input  logic              narrow,
    input  logic              trs,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] wide
);
    localparam int PAD_W = WORD_W - BYTE_W;

    generate
        if (PAD_W == 0) begin : g_no_pad
            logic unused_ctl;
            assign unused_ctl = narrow ^ trs;
            assign wide = word_in;
        end else begin : g_pad
            logic [BYTE_W-1:0] byte_v;
            logic              all_one;
            logic              all_zero;

            assign byte_v   = word_in[WORD_W-1 -: BYTE_W];
            assign all_one  = &byte_v;
            assign all_zero = ~|byte_v;

            always_comb begin
                if (!narrow) begin
                    wide = word_in;
                end else if (trs && all_one) begin
                    wide = '1;
                end else if (trs && all_zero) begin
                    wide = '0;
                end else begin
                    wide = {byte_v, {PAD_W{1'b0}}};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/svenc_serializer.sv
module svenc_serializer #(
    parameter int WORD_W = svenc_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] wide_word,
    output logic              load,
    output logic              locked,
    output logic              ser_bit
);
    import svenc_pkg::*;

    localparam int          CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    ser_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;

    assign locked  = (state_q == SER_RUN);
    assign load    = locked ? (cnt_q == LAST) : word_stb;
    assign ser_bit = shreg_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_WAIT;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (load) begin
            state_q <= SER_RUN;
            cnt_q   <= '0;
            shreg_q <= wide_word;
        end else begin
            shreg_q <= shreg_q >> 1;
            if (locked) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/svenc_scrambler.sv
module svenc_scrambler #(
    parameter int SCR_LEN = svenc_pkg::SCR_LEN,
    parameter int SCR_TAP = svenc_pkg::SCR_TAP
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic scr_bit
);
    localparam logic [SCR_LEN-1:0] MASK = svenc_pkg::tap_mask(SCR_LEN, SCR_TAP);

    logic [SCR_LEN-1:0] hist_q;

    assign scr_bit = bit_in ^ (^(hist_q & MASK));

    generate
        if (SCR_LEN > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else begin
                    hist_q <= {hist_q[SCR_LEN-2:0], scr_bit};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else begin
                    hist_q <= scr_bit;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/svenc_nrzi.sv
module svenc_nrzi (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic line_out
);
    logic level_q;

    assign line_out = level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else if (bit_in) begin
            level_q <= ~level_q;
        end
    end

endmodule

// File: rtl/serial_video_encoder.sv
module serial_video_encoder #(
    parameter int WORD_W  = svenc_pkg::WORD_W,
    parameter int BYTE_W  = svenc_pkg::BYTE_W,
    parameter int SCR_LEN = svenc_pkg::SCR_LEN,
    parameter int SCR_TAP = svenc_pkg::SCR_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_8bit,
    input  logic              word_stb,
    input  logic              trs_flag,
    input  logic [WORD_W-1:0] word_in,
    output logic              serial_out
);
    import svenc_pkg::*;

    vid_word_t         vin;
    logic [WORD_W-1:0] wide_word;
    logic              load;
    logic              locked;
    logic              ser_bit;
    logic              scr_bit;

    assign vin.narrow = mode_8bit;
    assign vin.trs    = trs_flag;
    assign vin.data   = word_in;

    svenc_widener #(
        .WORD_W(WORD_W),
        .BYTE_W(BYTE_W)
    ) u_widen (
        .narrow (vin.narrow),
        .trs    (vin.trs),
        .word_in(vin.data),
        .wide   (wide_word)
    );

    svenc_serializer #(
        .WORD_W(WORD_W)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb),
        .wide_word(wide_word),
        .load     (load),
        .locked   (locked),
        .ser_bit  (ser_bit)
    );

    svenc_scrambler #(
        .SCR_LEN(SCR_LEN),
        .SCR_TAP(SCR_TAP)
    ) u_scr (
        .clk    (clk),
        .rst    (rst),
        .bit_in (ser_bit),
        .scr_bit(scr_bit)
    );

    svenc_nrzi u_nrzi (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (scr_bit),
        .line_out(serial_out)
    );

endmodule

// File: rtl/svenc_checker.sv
module svenc_checker #(
    parameter int WORD_W = svenc_pkg::WORD_W,
    parameter int BYTE_W = svenc_pkg::BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_8bit,
    input logic              word_stb,
    input logic              trs_flag,
    input logic [WORD_W-1:0] word_in,
    input logic              load,
    input logic              locked,
    input logic              ser_bit,
    input logic              scr_bit,
    input logic              serial_out
);
    logic        armed_q;
    logic        seen_q;
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            seen_q  <= 1'b0;
            gap_q   <= 0;
        end else begin
            armed_q <= 1'b1;
            if (load) begin
                seen_q <= 1'b1;
                gap_q  <= 0;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !locked |-> serial_out == 1'b0);

    assert_strobe_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (locked && word_stb) |-> load);

    assert_load_period_R2: assert property (@(posedge clk) disable iff (rst)
        (load && seen_q) |-> gap_q == WORD_W - 1);

    assert_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !load) |-> gap_q < WORD_W - 1);

    assert_wide_lsb_R4: assert property (@(posedge clk) disable iff (rst)
        (load && !mode_8bit) |=> ser_bit == $past(word_in[0]));

    assert_trs_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (load && mode_8bit && trs_flag && (&word_in[WORD_W-1 -: BYTE_W])) |=> ser_bit);

    assert_trs_zeros_R6: assert property (@(posedge clk) disable iff (rst)
        (load && mode_8bit && trs_flag && !(|word_in[WORD_W-1 -: BYTE_W])) |=> !ser_bit);

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (load && mode_8bit && !trs_flag) |=> !ser_bit ##1 !ser_bit);

    assert_line_toggle_R9: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (serial_out != $past(serial_out)) == $past(scr_bit));

endmodule

bind serial_video_encoder svenc_checker #(
    .WORD_W(WORD_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_8bit (mode_8bit),
    .word_stb  (word_stb),
    .trs_flag  (trs_flag),
    .word_in   (word_in),
    .load      (load),
    .locked    (locked),
    .ser_bit   (ser_bit),
    .scr_bit   (scr_bit),
    .serial_out(serial_out)
);

// File: tb/tb_serial_video_encoder.sv
module tb_serial_video_encoder;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_8bit = 1'b0;
    logic       word_stb = 1'b0;
    logic       trs_flag = 1'b0;
    logic [9:0] word_in = '0;
    logic       serial_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state
    logic [8:0] m_hist = '0;
    logic       m_level = 1'b0;
    logic [9:0] m_sh = '0;
    string      m_tag = "R1";
    logic       rx_prev = 1'b0;
    logic [8:0] rx_hist = '0;

    serial_video_encoder dut (
        .clk       (clk),
        .rst       (rst),
        .mode_8bit (mode_8bit),
        .word_stb  (word_stb),
        .trs_flag  (trs_flag),
        .word_in   (word_in),
        .serial_out(serial_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] exp_word(input logic [9:0] w, input logic trs, input logic m8);
        if (!m8) return w;
        if (trs && w[9:2] == 8'hFF) return 10'h3FF;
        if (trs && w[9:2] == 8'h00) return 10'h000;
        return {w[9:2], 2'b00};
    endfunction

    // one fast-clock edge: model the bit taken at this edge, compare, recover
    task automatic step(input bit ld, input logic [9:0] nw, input string ntag);
        logic b, s, d, x;
        @(posedge clk);
        #1;
        b = m_sh[0];
        s = b ^ m_hist[8] ^ m_hist[3];
        m_hist = {m_hist[7:0], s};
        m_level = m_level ^ s;
        check(serial_out === m_level, "R8 R9 line level", 10'(serial_out), 10'(m_level));
        d = serial_out ^ rx_prev;
        rx_prev = serial_out;
        x = d ^ rx_hist[8] ^ rx_hist[3];
        rx_hist = {rx_hist[7:0], d};
        check(x === b, {"R2 R3 R9 recovered bit, word tag ", m_tag}, 10'(x), 10'(b));
        if (ld) begin
            m_sh = nw;
            m_tag = ntag;
        end else begin
            m_sh = m_sh >> 1;
        end
    endtask

    task automatic send(input logic [9:0] w, input logic trs, input logic m8, input string tag);
        @(negedge clk);
        word_in = w;
        trs_flag = trs;
        mode_8bit = m8;
        word_stb = 1'b1;
        step(1'b1, exp_word(w, trs, m8), tag);
        word_stb = 1'b0;
        word_in = 10'h2A5;
        trs_flag = ~trs;
        for (int k = 0; k < 9; k++) step(1'b0, '0, "");
    endtask

    task automatic test_reset_idle();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(serial_out === 1'b0, "R1 reset level", 10'(serial_out), 10'h0);
        word_in = 10'h3FF;
        mode_8bit = 1'b0;
        for (int k = 0; k < 13; k++) begin
            step(1'b0, '0, "");
            check(serial_out === 1'b0, "R1 idle before strobe", 10'(serial_out), 10'h0);
        end
    endtask

    task automatic test_ten_bit();
        send(10'h3FF, 1'b0, 1'b0, "R4 all ones");
        send(10'h000, 1'b1, 1'b0, "R4 zero with flag");
        send(10'h3FF, 1'b1, 1'b0, "R4 ones with flag");
        send(10'h001, 1'b0, 1'b0, "R3 R4 lsb only");
        send(10'h200, 1'b0, 1'b0, "R3 R4 msb only");
        send(10'h155, 1'b0, 1'b0, "R4 alternating");
        send(10'h0AB, 1'b1, 1'b0, "R4 mixed");
    endtask

    task automatic test_trs_codes();
        send(10'h3FC, 1'b1, 1'b1, "R5 ones code");
        send(10'h003, 1'b1, 1'b1, "R6 zero code");
        send(10'h3FF, 1'b1, 1'b1, "R5 ones code junk lsb");
        send(10'h000, 1'b1, 1'b1, "R6 zero code clean");
    endtask

    task automatic test_pad();
        send(10'h3FF, 1'b0, 1'b1, "R7 ones without flag");
        send(10'h203, 1'b1, 1'b1, "R7 other byte with flag");
        send(10'h15B, 1'b0, 1'b1, "R7 junk lsb");
        send(10'h101, 1'b0, 1'b1, "R7 byte 40");
    endtask

    task automatic test_long_stream();
        for (int i = 0; i < 48; i++) begin
            send(10'((i * 37 + 5) % 1024), i[0], i[2], "R8 long stream");
        end
        send(10'h200, 1'b0, 1'b0, "R8 flush");
        send(10'h040, 1'b0, 1'b0, "R8 flush");
    endtask

    initial begin
        test_reset_idle();
        test_ten_bit();
        test_trs_codes();
        test_pad();
        test_long_stream();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule